// File: doc/BRIEF.md
# Touch Panel Controller Bring-Up and Poll Sequencer

This block brings up a resistive touch-panel controller chip that sits on an I2C bus, and then keeps asking it whether the panel is being pressed. It does not toggle the bus wires itself. It drives a byte-level I2C master through a simple request interface. A request names the 7-bit target address, the direction, a byte count of one or two, up to two bytes to send, and whether the transaction ends with a stop or with a repeated start. The master answers with a one-cycle done pulse, an acknowledge flag and the byte it read.

After reset the sequencer plays a fixed list of eleven register writes into the chip. Every transaction is followed by a settling wait whose length is a parameter in clock cycles; the default is 100 ms at 50 MHz. Once the list has gone through, the sequencer polls the chip's control register. A poll is a one-byte write of the register number that ends in a repeated start, followed by a one-byte read that ends in a stop. The top bit of the byte read back becomes a registered touch flag. The flag comes with a one-cycle valid strobe. Polls repeat with an idle gap set by a run-time input.

If the chip fails to acknowledge any transaction, the sequencer sets a sticky error flag, drops its ready indication and starts the write list again from its first entry.

Top module: `tsc_poll_seq`

## Requirements
- R1: While reset is held, req_valid, touched, touch_valid, init_done and err_flag are all 0. After release, the first request appears SETTLE_CYC cycles later: req_valid is low for exactly SETTLE_CYC sampled cycles, counting the cycle of release.
- R2: The bring-up list is exactly these eleven writes, given as register then value, in this order: 03/02, 04/00, 40/01, 20/50, 21/02, 41/A4, 56/06, 4A/01, 4B/01, 4B/00, 58/01 (hex).
- R3: Every bring-up write has req_addr = 0x41, req_rnw = 0 (1 means read), req_len = 2, req_byte0 = register, req_byte1 = value and req_stop = 1 (1 means stop, 0 means repeated start).
- R4: Register 0x4B is written twice back to back, first with 0x01 and then with 0x00, and no other write comes between the two.
- R5: After a done pulse for a bring-up write, for a poll write, or for any non-acknowledged transaction, req_valid stays low for exactly SETTLE_CYC cycles before the next request.
- R6: A poll is a write with req_len = 1, req_byte0 = 0x40 and req_stop = 0. If that write is acknowledged, it is followed by a read with req_rnw = 1, req_len = 1 and req_stop = 1.
- R7: After the last bring-up write is acknowledged, and after every acknowledged poll read, req_valid stays low for exactly SETTLE_CYC + poll_period + 1 cycles.
- R8: In the cycle after an acknowledged poll read completes, touched equals bit 7 of xfer_rdata and touch_valid is 1 for that one cycle only.
- R9: touched does not change except on a touch_valid cycle. A non-acknowledged read and a poll write leave it unchanged.
- R10: A done pulse with xfer_ack = 0 sets err_flag, which then stays set until reset. It also clears init_done, and the next request is bring-up write 03/02.
- R11: init_done rises in the cycle after the last bring-up write is acknowledged. No poll request is made while init_done is 0.
- R12: While req_valid is high and no done pulse has arrived, every request field stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poll_period | input | CNT_W | Extra idle cycles between polls |
| req_valid | output | 1 | Request pending, held until xfer_done |
| req_addr | output | 7 | Target device address |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_len | output | 2 | Number of data bytes |
| req_byte0 | output | 8 | First byte to send |
| req_byte1 | output | 8 | Second byte to send |
| req_stop | output | 1 | 1 = end with stop, 0 = end with repeated start |
| xfer_done | input | 1 | One-cycle completion pulse from the master |
| xfer_ack | input | 1 | 1 = every byte was acknowledged |
| xfer_rdata | input | 8 | Byte read by the master |
| touched | output | 1 | Latest touch state |
| touch_valid | output | 1 | One-cycle strobe on each touch update |
| init_done | output | 1 | Bring-up list finished, polling active |
| err_flag | output | 1 | Sticky NACK indication |

## Verification
The bench feeds the sequencer non-acknowledged transactions at several points: on a bring-up write in the middle of the list, on a poll write and on a poll read. A design that resumed the list instead of restarting it, or that kept init_done high, would issue the wrong next request. A design that treated the failed read as a result would change touched. The bench also counts the exact idle length after each kind of transaction, so a settling wait that is one cycle off, or a poll gap applied after the poll write instead of after the read, shows up as a wrong count. Read-back bytes of 0x7F and 0xC1 check that only bit 7 decides the touch state. The back-to-back pair of writes to register 0x4B is compared entry by entry, so a list that is reordered or shortened is caught.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Number of register writes in the bring-up list
    localparam int unsigned SCRIPT_LEN = 11;
    localparam int unsigned IDX_W      = $clog2(SCRIPT_LEN);

    // Register polled for the touch state and the bit that flags a press
    localparam logic [7:0] STATUS_REG = 8'h40;
    localparam logic [7:0] TOUCH_MASK = 8'h80;

    typedef enum logic [1:0] {
        ST_REQ,
        ST_SETTLE,
        ST_GAP
    } seq_st_e;

    typedef enum logic [1:0] {
        PH_INIT,
        PH_POLL_WR,
        PH_POLL_RD
    } seq_ph_e;

    typedef struct packed {
        logic [7:0] reg_addr;
        logic [7:0] value;
    } wr_pair_t;

    typedef struct packed {
        seq_st_e          st;
        seq_ph_e          ph;
        logic [IDX_W-1:0] idx;
        logic             init_done;
        logic             err;
        logic             touched;
        logic             tvalid;
    } seq_regs_t;

endpackage

// File: rtl/tsc_script_rom.sv
module tsc_script_rom
    import tsc_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output wr_pair_t         pair,
    output logic             last
);

    always_comb begin
        case (idx)
            4'd0:    pair = '{reg_addr: 8'h03, value: 8'h02}; // soft reset
            4'd1:    pair = '{reg_addr: 8'h04, value: 8'h00}; // clocks on
            4'd2:    pair = '{reg_addr: 8'h40, value: 8'h01}; // sensing mode
            4'd3:    pair = '{reg_addr: 8'h20, value: 8'h50};
            4'd4:    pair = '{reg_addr: 8'h21, value: 8'h02};
            4'd5:    pair = '{reg_addr: 8'h41, value: 8'hA4};
            4'd6:    pair = '{reg_addr: 8'h56, value: 8'h06};
            4'd7:    pair = '{reg_addr: 8'h4A, value: 8'h01};
            4'd8:    pair = '{reg_addr: 8'h4B, value: 8'h01}; // queue reset set
            4'd9:    pair = '{reg_addr: 8'h4B, value: 8'h00}; // queue reset clear
            4'd10:   pair = '{reg_addr: 8'h58, value: 8'h01};
            default: pair = '{reg_addr: 8'h00, value: 8'h00};
        endcase
    end

    assign last = (idx == IDX_W'(SCRIPT_LEN - 1));

endmodule

// File: rtl/tsc_wait_timer.sv
module tsc_wait_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != '1) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/tsc_req_fmt.sv
module tsc_req_fmt
    import tsc_pkg::*;
(
    input  seq_ph_e    ph,
    input  wr_pair_t   pair,
    output logic       rnw,
    output logic [1:0] len,
    output logic [7:0] byte0,
    output logic [7:0] byte1,
    output logic       stop
);

    always_comb begin
        rnw   = 1'b0;
        len   = 2'd1;
        byte0 = 8'h00;
        byte1 = 8'h00;
        stop  = 1'b1;
        case (ph)
            PH_INIT: begin
                len   = 2'd2;
                byte0 = pair.reg_addr;
                byte1 = pair.value;
            end
            PH_POLL_WR: begin
                byte0 = STATUS_REG;
                stop  = 1'b0;
            end
            PH_POLL_RD: begin
                rnw = 1'b1;
            end
            default: begin
                len = 2'd1;
            end
        endcase
    end

endmodule

// File: rtl/tsc_poll_seq.sv
module tsc_poll_seq
    import tsc_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR   = 7'h41,
    parameter int unsigned SETTLE_CYC = 5_000_000,
    parameter int unsigned CNT_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] poll_period,
    output logic             req_valid,
    output logic [6:0]       req_addr,
    output logic             req_rnw,
    output logic [1:0]       req_len,
    output logic [7:0]       req_byte0,
    output logic [7:0]       req_byte1,
    output logic             req_stop,
    input  logic             xfer_done,
    input  logic             xfer_ack,
    input  logic [7:0]       xfer_rdata,
    output logic             touched,
    output logic             touch_valid,
    output logic             init_done,
    output logic             err_flag
);

    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);

    localparam seq_regs_t REGS_RST = '{
        st:        ST_SETTLE,
        ph:        PH_INIT,
        idx:       '0,
        init_done: 1'b0,
        err:       1'b0,
        touched:   1'b0,
        tvalid:    1'b0
    };

    seq_regs_t        r_d, r_q;
    wr_pair_t         pair;
    logic             rom_last;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_limit;
    logic             tmr_expired;

    tsc_script_rom u_rom (
        .idx  (r_q.idx),
        .pair (pair),
        .last (rom_last)
    );

    tsc_wait_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    tsc_req_fmt u_fmt (
        .ph    (r_q.ph),
        .pair  (pair),
        .rnw   (req_rnw),
        .len   (req_len),
        .byte0 (req_byte0),
        .byte1 (req_byte1),
        .stop  (req_stop)
    );

    always_comb begin
        r_d        = r_q;
        r_d.tvalid = 1'b0;
        tmr_clr    = 1'b0;
        tmr_limit  = SETTLE_LIM;

        case (r_q.st)
            ST_REQ: begin
                tmr_clr = 1'b1;
                if (xfer_done) begin
                    r_d.st = ST_SETTLE;
                    if (!xfer_ack) begin
                        r_d.err       = 1'b1;
                        r_d.init_done = 1'b0;
                        r_d.ph        = PH_INIT;
                        r_d.idx       = '0;
                    end else begin
                        case (r_q.ph)
                            PH_INIT: begin
                                if (rom_last) begin
                                    r_d.init_done = 1'b1;
                                    r_d.ph        = PH_POLL_WR;
                                    r_d.idx       = '0;
                                end else begin
                                    r_d.idx = r_q.idx + IDX_W'(1);
                                end
                            end
                            PH_POLL_WR: begin
                                r_d.ph = PH_POLL_RD;
                            end
                            PH_POLL_RD: begin
                                r_d.touched = |(xfer_rdata & TOUCH_MASK);
                                r_d.tvalid  = 1'b1;
                                r_d.ph      = PH_POLL_WR;
                            end
                            default: begin
                                r_d.ph = PH_INIT;
                            end
                        endcase
                    end
                end
            end
            ST_SETTLE: begin
                tmr_limit = SETTLE_LIM;
                if (tmr_expired) begin
                    tmr_clr = 1'b1;
                    r_d.st  = (r_q.ph == PH_POLL_WR) ? ST_GAP : ST_REQ;
                end
            end
            ST_GAP: begin
                tmr_limit = poll_period;
                if (tmr_expired) begin
                    r_d.st = ST_REQ;
                end
            end
            default: begin
                r_d.st = ST_SETTLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid   = (r_q.st == ST_REQ);
    assign req_addr    = DEV_ADDR;
    assign touched     = r_q.touched;
    assign touch_valid = r_q.tvalid;
    assign init_done   = r_q.init_done;
    assign err_flag    = r_q.err;

endmodule

// File: rtl/tsc_poll_seq_chk.sv
module tsc_poll_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_rnw,
    input logic [1:0] req_len,
    input logic [7:0] req_byte0,
    input logic [7:0] req_byte1,
    input logic       req_stop,
    input logic       xfer_done,
    input logic       xfer_ack,
    input logic       touched,
    input logic       touch_valid,
    input logic       init_done,
    input logic       err_flag
);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xfer_done |=> req_valid &&
            $stable({req_rnw, req_len, req_byte0, req_byte1, req_stop}));

    // R5
    settle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && xfer_done |=> !req_valid);

    // R8
    touch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |-> $past(req_valid && req_rnw && xfer_done && xfer_ack));

    // R8
    touch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> !touch_valid);

    // R9
    touch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_valid |-> $stable(touched));

    // R10
    nack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && xfer_done && !xfer_ack |=> err_flag && !init_done);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R11
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(req_valid && xfer_done && xfer_ack));

    // R11
    poll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_rnw || !req_stop) |-> init_done);

endmodule

bind tsc_poll_seq tsc_poll_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_rnw     (req_rnw),
    .req_len     (req_len),
    .req_byte0   (req_byte0),
    .req_byte1   (req_byte1),
    .req_stop    (req_stop),
    .xfer_done   (xfer_done),
    .xfer_ack    (xfer_ack),
    .touched     (touched),
    .touch_valid (touch_valid),
    .init_done   (init_done),
    .err_flag    (err_flag)
);

// File: tb/sim_tsc_poll_seq.sv
`timescale 1ns/1ps
module sim_tsc_poll_seq;

    localparam int S   = 12;
    localparam int P   = 7;
    localparam int LAT = 3;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] poll_period;
    logic          req_valid, req_rnw, req_stop;
    logic [6:0]    req_addr;
    logic [1:0]    req_len;
    logic [7:0]    req_byte0, req_byte1;
    logic          xfer_done, xfer_ack;
    logic [7:0]    xfer_rdata;
    logic          touched, touch_valid, init_done, err_flag;

    always #10 clk = ~clk;

    tsc_poll_seq #(.DEV_ADDR(7'h41), .SETTLE_CYC(S), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .poll_period(poll_period),
        .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_len(req_len), .req_byte0(req_byte0), .req_byte1(req_byte1),
        .req_stop(req_stop), .xfer_done(xfer_done), .xfer_ack(xfer_ack),
        .xfer_rdata(xfer_rdata), .touched(touched), .touch_valid(touch_valid),
        .init_done(init_done), .err_flag(err_flag)
    );

    typedef struct {
        bit         rnw;
        bit [1:0]   len;
        bit [7:0]   b0;
        bit [7:0]   b1;
        bit         stop;
        bit         ack;
        bit [7:0]   rd;
        int         kind;
        int         gap;
        bit         e_init;
        bit         e_err;
        bit         e_touch;
        bit         e_valid;
    } item_t;

    item_t q[$];
    bit    m_init, m_err, m_touch;
    int    checks, errors;
    bit    finished;

    // R2 list, register then value
    bit [7:0] scr_reg [11] = '{8'h03, 8'h04, 8'h40, 8'h20, 8'h21, 8'h41,
                               8'h56, 8'h4A, 8'h4B, 8'h4B, 8'h58};
    bit [7:0] scr_val [11] = '{8'h02, 8'h00, 8'h01, 8'h50, 8'h02, 8'hA4,
                               8'h06, 8'h01, 8'h01, 8'h00, 8'h01};

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic item_t stamp(input item_t it);
        item_t o = it;
        o.e_init  = m_init;
        o.e_err   = m_err;
        o.e_touch = m_touch;
        return o;
    endfunction

    // Driver: pushes a bring-up pass; nack_at < 0 means all acknowledged
    task automatic push_init(input int nack_at);
        for (int i = 0; i < 11; i++) begin
            item_t it;
            it = '{rnw: 1'b0, len: 2'd2, b0: scr_reg[i], b1: scr_val[i],
                   stop: 1'b1, ack: 1'b1, rd: 8'h00, kind: 0, gap: S,
                   e_init: 1'b0, e_err: 1'b0, e_touch: 1'b0, e_valid: 1'b0};
            if (i == nack_at) begin
                it.ack = 1'b0;
                m_err  = 1'b1;
                m_init = 1'b0;
                q.push_back(stamp(it));
                return;
            end
            if (i == 10) begin
                m_init = 1'b1;
                it.gap = S + P + 1;
            end
            q.push_back(stamp(it));
        end
    endtask

    task automatic push_poll(input bit [7:0] rd, input bit wack, input bit rack);
        item_t w, r;
        w = '{rnw: 1'b0, len: 2'd1, b0: 8'h40, b1: 8'h00, stop: 1'b0,
              ack: wack, rd: 8'h00, kind: 1, gap: S,
              e_init: 1'b0, e_err: 1'b0, e_touch: 1'b0, e_valid: 1'b0};
        if (!wack) begin
            m_err  = 1'b1;
            m_init = 1'b0;
            q.push_back(stamp(w));
            return;
        end
        q.push_back(stamp(w));
        r = '{rnw: 1'b1, len: 2'd1, b0: 8'h00, b1: 8'h00, stop: 1'b1,
              ack: rack, rd: rd, kind: 2, gap: S,
              e_init: 1'b0, e_err: 1'b0, e_touch: 1'b0, e_valid: 1'b0};
        if (rack) begin
            m_touch   = rd[7];
            r.e_valid = 1'b1;
            r.gap     = S + P + 1;
        end else begin
            m_err  = 1'b1;
            m_init = 1'b0;
        end
        q.push_back(stamp(r));
    endtask

    function automatic logic [31:0] pack_req(input bit rnw, input bit [1:0] len,
            input bit [7:0] b0, input bit [7:0] b1, input bit stop, input int kind);
        bit [7:0] m0, m1;
        m0 = (kind == 2) ? 8'h00 : b0;
        m1 = (kind == 0) ? b1 : 8'h00;
        return {12'h0, rnw, len, m0, m1, stop};
    endfunction

    // Driver
    initial begin
        m_init = 0; m_err = 0; m_touch = 0;
        push_init(-1);
        push_poll(8'h80, 1, 1);
        push_poll(8'h7F, 1, 1);
        push_poll(8'hC1, 1, 1);
        push_poll(8'hFF, 1, 0);
        push_init(4);
        push_init(-1);
        push_poll(8'h00, 0, 1);
        push_init(-1);
        push_poll(8'h00, 1, 1);
        push_poll(8'h80, 1, 1);
    end

    // Monitor and master model
    initial begin
        int n;
        checks = 0; errors = 0; finished = 0;
        rst_n = 1'b0; xfer_done = 1'b0; xfer_ack = 1'b0; xfer_rdata = 8'h00;
        poll_period = CW'(P);
        repeat (4) @(negedge clk);
        chk(req_valid == 1'b0, "R1", "req_valid in reset", 32'(req_valid), 0);
        chk({touched, touch_valid, init_done, err_flag} == 4'b0, "R1",
            "status in reset", 32'({touched, touch_valid, init_done, err_flag}), 0);
        rst_n = 1'b1;
        n = 0;
        while (!req_valid && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk(n == S, "R1", "first request delay", 32'(n), 32'(S));

        while (q.size() > 0) begin
            item_t it;
            string tg;
            logic [31:0] a0, e0;
            it = q.pop_front();
            if (it.kind == 0) tg = (it.b0 == 8'h4B) ? "R4" : "R2/R3";
            else tg = "R6";
            e0 = pack_req(it.rnw, it.len, it.b0, it.b1, it.stop, it.kind);
            a0 = pack_req(req_rnw, req_len, req_byte0, req_byte1, req_stop, it.kind);
            chk(a0 == e0, tg, "request fields", a0, e0);
            chk(req_addr == 7'h41, "R3", "device address", 32'(req_addr), 32'h41);
            repeat (LAT) @(negedge clk);
            a0 = pack_req(req_rnw, req_len, req_byte0, req_byte1, req_stop, it.kind);
            chk(req_valid && a0 == e0, "R12", "request held", a0, e0);
            xfer_done = 1'b1; xfer_ack = it.ack; xfer_rdata = it.rd;
            @(negedge clk);
            xfer_done = 1'b0; xfer_ack = 1'b0; xfer_rdata = 8'h00;
            chk(touch_valid == it.e_valid, "R8", "touch_valid",
                32'(touch_valid), 32'(it.e_valid));
            chk(touched == it.e_touch, it.e_valid ? "R8" : "R9", "touched",
                32'(touched), 32'(it.e_touch));
            chk(init_done == it.e_init, it.ack ? "R11" : "R10", "init_done",
                32'(init_done), 32'(it.e_init));
            chk(err_flag == it.e_err, "R10", "err_flag", 32'(err_flag), 32'(it.e_err));
            if (q.size() > 0) begin
                n = 0;
                while (!req_valid && n < 100000) begin
                    n++;
                    @(negedge clk);
                    if (n == 1 && it.e_valid)
                        chk(touch_valid == 1'b0, "R8", "strobe width", 32'(touch_valid), 0);
                end
                chk(n == it.gap, (it.gap == S) ? "R5" : "R7", "idle cycles",
                    32'(n), 32'(it.gap));
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule